// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencing Controller

This block is the control unit of a small 16-bit multi-cycle processor. It watches the opcode and function fields of the instruction register, plus an equality status bit from the datapath. It then steps through a state machine that produces one control word per clock. That word drives the datapath strobes:

- whether the program counter drives the memory address bus;
- memory read and memory write;
- instruction-register load;
- program-counter load and the source of the new PC value;
- the two ALU operand selects and the ALU operation;
- register-file write, the source of the write data, and which field names the destination register.

Every instruction starts with a shared fetch cycle and a shared decode cycle. During fetch the instruction is read from memory while the same ALU adds one to the PC. Decode picks the execute sequence from the opcode and, for register-register instructions, the function code. Each instruction class then runs one to three execute states of its own and returns to fetch. The controller is a Moore machine: its outputs depend only on the present state, and a synchronous active-high reset returns it to fetch.

Top module: `mpc_ctrl`

## Requirements
- R1: A cycle with `rst` high at the rising edge leaves the controller in the fetch state, from any state (halt and mid-instruction states included). The fetch control word therefore appears in the following cycle.
- R2: The fetch word has `pc_to_addr`, `mem_rd`, `ir_ld` and `pc_ld` set to 1, with `pc_src`=0 (ALU result), `alu_a_sel`=0 (PC), `alu_b_sel`=1 (constant one) and `alu_op`=0 (add). All other outputs are 0.
- R3: Fetch is always followed by exactly one decode cycle in which every output is 0. The next state is chosen from `ir_op` and `ir_funct` as they stand during decode.
- R4: Opcode 0 with function 0..4 runs one execute cycle and then returns to fetch. That cycle has `alu_a_sel`=1 (register A), `alu_b_sel`=0 (register B), `rf_wr`=1, `wd_sel`=0 (ALU) and `wr_reg_sel`=1 (rd). Its `alu_op` equals the function code: 0 add, 1 sub, 2 and, 3 or, 4 set-less-than.
- R5: Opcode 4 (add immediate) runs one execute cycle and then returns to fetch. That cycle has `alu_a_sel`=1, `alu_b_sel`=2 (sign-extended offset), `alu_op`=0, `rf_wr`=1, `wd_sel`=0 and `wr_reg_sel`=0 (rt).
- R6: Opcode 1 (load) runs three execute cycles in order:
  - an address cycle with `alu_a_sel`=1, `alu_b_sel`=2 and add;
  - a read cycle with the same ALU setting plus `mem_rd`=1 and `pc_to_addr`=0;
  - a write-back cycle with `rf_wr`=1, `wd_sel`=1 (memory) and `wr_reg_sel`=0.
- R7: Opcode 2 (store) runs two execute cycles: the address cycle of R6, then a cycle with the same ALU setting and `mem_wr`=1. It then returns to fetch.
- R8: Opcode 3 (branch if equal) runs a compare cycle with `alu_a_sel`=1, `alu_b_sel`=0 and `alu_op`=1 (sub). If `eq_flag` is 1 at the end of that cycle, a taken cycle follows with `pc_ld`=1, `pc_src`=0, `alu_a_sel`=0, `alu_b_sel`=2 and add. Otherwise fetch follows directly.
- R9: Opcode 5 (jump) runs one cycle with `pc_ld`=1 and `pc_src`=1 (jump target from the instruction), then returns to fetch.
- R10: Opcode 7 (halt) enters an idle state after decode. In that state every output is 0 and stays 0 whatever the inputs do, until reset.
- R11: Opcode 6, or opcode 0 with a function code of 5 to 15, goes straight from decode to fetch without asserting `rf_wr`, `mem_wr` or `pc_ld`.
- R12: `mem_rd` and `mem_wr` are never both 1. At most one of `rf_wr`, `mem_wr`, and `pc_ld` outside fetch is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ir_op | input | 3 | Opcode field of the instruction register |
| ir_funct | input | 4 | Function field of the instruction register |
| eq_flag | input | 1 | Datapath equality status (operands equal) |
| pc_to_addr | output | 1 | PC drives the memory address bus |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_ld | output | 1 | Instruction register load |
| pc_ld | output | 1 | Program counter load |
| pc_src | output | 1 | PC source: 0 ALU result, 1 jump target |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 0 register B, 1 constant one, 2 offset |
| alu_op | output | 3 | ALU operation: 0 add, 1 sub, 2 and, 3 or, 4 slt |
| rf_wr | output | 1 | Register-file write enable |
| wd_sel | output | 1 | Write data: 0 ALU result, 1 memory data |
| wr_reg_sel | output | 1 | Destination register: 0 rt, 1 rd |

## Verification
In the fetch cycle, two jobs overlap. The instruction read loads the IR, and the shared ALU computes PC plus one, which the PC loads at the same edge. Every instruction in the random stream and in the directed cases provokes this overlap. The bench judges it by comparing the whole control word each fetch cycle against the R2 word, so a lost increment or a lost IR load is reported. A second overlap comes from reset arriving in the middle of a load or during halt. The bench injects it by asserting reset in those states. It then requires the fetch word in the next cycle, which shows that reset takes precedence over the in-flight sequence.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    localparam int OP_W = 3;
    localparam int FN_W = 4;
    localparam int ALU_OP_W = 3;
    localparam int BSEL_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_RTYPE = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_BEQ   = 3'd3,
        OP_ADDI  = 3'd4,
        OP_JUMP  = 3'd5,
        OP_RSVD  = 3'd6,
        OP_HALT  = 3'd7
    } opcode_e;

    typedef enum logic [ALU_OP_W-1:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef enum logic [BSEL_W-1:0] {
        B_REG = 2'd0,
        B_ONE = 2'd1,
        B_IMM = 2'd2
    } bsel_e;

    typedef enum logic [4:0] {
        S_FETCH,
        S_DECODE,
        S_RADD,
        S_RSUB,
        S_RAND,
        S_ROR,
        S_RSLT,
        S_ADDI,
        S_LADDR,
        S_LMEM,
        S_LWB,
        S_SADDR,
        S_SMEM,
        S_BCMP,
        S_BTAKE,
        S_JUMP,
        S_HALT
    } state_e;

    typedef struct packed {
        logic    pc_to_addr;
        logic    mem_rd;
        logic    mem_wr;
        logic    ir_ld;
        logic    pc_ld;
        logic    pc_src;
        logic    alu_a_sel;
        bsel_e   alu_b_sel;
        alu_op_e alu_op;
        logic    rf_wr;
        logic    wd_sel;
        logic    wr_reg_sel;
    } cword_t;

    localparam cword_t CW_IDLE = '{
        pc_to_addr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0, ir_ld: 1'b0,
        pc_ld: 1'b0, pc_src: 1'b0, alu_a_sel: 1'b0, alu_b_sel: B_REG,
        alu_op: ALU_ADD, rf_wr: 1'b0, wd_sel: 1'b0, wr_reg_sel: 1'b0
    };

    // Register-register execute state for a function code; fetch if undefined.
    function automatic state_e funct_state(input logic [FN_W-1:0] fn);
        case (fn)
            4'd0:    funct_state = S_RADD;
            4'd1:    funct_state = S_RSUB;
            4'd2:    funct_state = S_RAND;
            4'd3:    funct_state = S_ROR;
            4'd4:    funct_state = S_RSLT;
            default: funct_state = S_FETCH;
        endcase
    endfunction

    // ALU operation used by a register-register execute state.
    function automatic alu_op_e rstate_alu(input state_e st);
        case (st)
            S_RSUB:  rstate_alu = ALU_SUB;
            S_RAND:  rstate_alu = ALU_AND;
            S_ROR:   rstate_alu = ALU_OR;
            S_RSLT:  rstate_alu = ALU_SLT;
            default: rstate_alu = ALU_ADD;
        endcase
    endfunction

endpackage

// File: rtl/mpc_dispatch.sv
module mpc_dispatch
    import mpc_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic [FN_W-1:0] funct,
    output state_e          target
);
    always_comb begin
        case (opcode_e'(op))
            OP_RTYPE: target = funct_state(funct);
            OP_LOAD:  target = S_LADDR;
            OP_STORE: target = S_SADDR;
            OP_BEQ:   target = S_BCMP;
            OP_ADDI:  target = S_ADDI;
            OP_JUMP:  target = S_JUMP;
            OP_HALT:  target = S_HALT;
            default:  target = S_FETCH;
        endcase
    end
endmodule

// File: rtl/mpc_next.sv
module mpc_next
    import mpc_pkg::*;
(
    input  state_e cur,
    input  state_e dispatch,
    input  logic   eq,
    output state_e nxt
);
    always_comb begin
        case (cur)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: nxt = dispatch;
            S_LADDR:  nxt = S_LMEM;
            S_LMEM:   nxt = S_LWB;
            S_SADDR:  nxt = S_SMEM;
            S_BCMP:   nxt = eq ? S_BTAKE : S_FETCH;
            S_HALT:   nxt = S_HALT;
            default:  nxt = S_FETCH;
        endcase
    end
endmodule

// File: rtl/mpc_cword.sv
module mpc_cword
    import mpc_pkg::*;
(
    input  state_e cur,
    output cword_t cw
);
    always_comb begin
        cw = CW_IDLE;
        case (cur)
            S_FETCH: begin
                cw.pc_to_addr = 1'b1;
                cw.mem_rd     = 1'b1;
                cw.ir_ld      = 1'b1;
                cw.pc_ld      = 1'b1;
                cw.alu_b_sel  = B_ONE;
            end
            S_RADD, S_RSUB, S_RAND, S_ROR, S_RSLT: begin
                cw.alu_a_sel  = 1'b1;
                cw.alu_op     = rstate_alu(cur);
                cw.rf_wr      = 1'b1;
                cw.wr_reg_sel = 1'b1;
            end
            S_ADDI: begin
                cw.alu_a_sel = 1'b1;
                cw.alu_b_sel = B_IMM;
                cw.rf_wr     = 1'b1;
            end
            S_LADDR, S_SADDR: begin
                cw.alu_a_sel = 1'b1;
                cw.alu_b_sel = B_IMM;
            end
            S_LMEM: begin
                cw.alu_a_sel = 1'b1;
                cw.alu_b_sel = B_IMM;
                cw.mem_rd    = 1'b1;
            end
            S_LWB: begin
                cw.rf_wr  = 1'b1;
                cw.wd_sel = 1'b1;
            end
            S_SMEM: begin
                cw.alu_a_sel = 1'b1;
                cw.alu_b_sel = B_IMM;
                cw.mem_wr    = 1'b1;
            end
            S_BCMP: begin
                cw.alu_a_sel = 1'b1;
                cw.alu_op    = ALU_SUB;
            end
            S_BTAKE: begin
                cw.pc_ld     = 1'b1;
                cw.alu_b_sel = B_IMM;
            end
            S_JUMP: begin
                cw.pc_ld  = 1'b1;
                cw.pc_src = 1'b1;
            end
            default: cw = CW_IDLE;
        endcase
    end
endmodule

// File: rtl/mpc_ctrl.sv
module mpc_ctrl
    import mpc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OP_W-1:0]     ir_op,
    input  logic [FN_W-1:0]     ir_funct,
    input  logic                eq_flag,
    output logic                pc_to_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic                ir_ld,
    output logic                pc_ld,
    output logic                pc_src,
    output logic                alu_a_sel,
    output logic [BSEL_W-1:0]   alu_b_sel,
    output logic [ALU_OP_W-1:0] alu_op,
    output logic                rf_wr,
    output logic                wd_sel,
    output logic                wr_reg_sel
);
    state_e state_q;
    state_e state_d;
    state_e dispatch;
    cword_t cw;

    mpc_dispatch u_dispatch (
        .op     (ir_op),
        .funct  (ir_funct),
        .target (dispatch)
    );

    mpc_next u_next (
        .cur      (state_q),
        .dispatch (dispatch),
        .eq       (eq_flag),
        .nxt      (state_d)
    );

    mpc_cword u_cword (
        .cur (state_q),
        .cw  (cw)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_FETCH;
        else     state_q <= state_d;
    end

    assign pc_to_addr = cw.pc_to_addr;
    assign mem_rd     = cw.mem_rd;
    assign mem_wr     = cw.mem_wr;
    assign ir_ld      = cw.ir_ld;
    assign pc_ld      = cw.pc_ld;
    assign pc_src     = cw.pc_src;
    assign alu_a_sel  = cw.alu_a_sel;
    assign alu_b_sel  = cw.alu_b_sel;
    assign alu_op     = cw.alu_op;
    assign rf_wr      = cw.rf_wr;
    assign wd_sel     = cw.wd_sel;
    assign wr_reg_sel = cw.wr_reg_sel;
endmodule

// File: rtl/mpc_ctrl_chk.sv
module mpc_ctrl_chk
    import mpc_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input state_e state,
    input logic   pc_to_addr,
    input logic   mem_rd,
    input logic   mem_wr,
    input logic   ir_ld,
    input logic   pc_ld,
    input logic   rf_wr
);
    AST_FETCH_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ir_ld && pc_ld)); // R1

    AST_FETCH_READS_PC: assert property (@(posedge clk) disable iff (rst)
        ir_ld |-> (mem_rd && pc_to_addr && pc_ld)); // R2

    AST_DECODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ir_ld |=> (!ir_ld && !rf_wr && !pc_ld && !mem_rd && !mem_wr)); // R3

    AST_WRITE_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        rf_wr |=> ir_ld); // R4

    AST_STORE_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_ld); // R7

    AST_PCLOAD_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        (pc_ld && !ir_ld) |=> ir_ld); // R9

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == S_HALT) |=> (state == S_HALT && !ir_ld)); // R10

    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R12

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_wr, mem_wr, pc_ld && !ir_ld})); // R12
endmodule

bind mpc_ctrl mpc_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .state      (state_q),
    .pc_to_addr (pc_to_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .ir_ld      (ir_ld),
    .pc_ld      (pc_ld),
    .rf_wr      (rf_wr)
);

// File: tb/tb_mpc_ctrl.sv
module tb_mpc_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] ir_op = 3'd0;
    logic [3:0] ir_funct = 4'd0;
    logic       eq_flag = 1'b0;
    logic       pc_to_addr, mem_rd, mem_wr, ir_ld, pc_ld, pc_src, alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [2:0] alu_op;
    logic       rf_wr, wd_sel, wr_reg_sel;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mpc_ctrl dut (
        .clk(clk), .rst(rst), .ir_op(ir_op), .ir_funct(ir_funct), .eq_flag(eq_flag),
        .pc_to_addr(pc_to_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld),
        .pc_ld(pc_ld), .pc_src(pc_src), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .alu_op(alu_op), .rf_wr(rf_wr), .wd_sel(wd_sel), .wr_reg_sel(wr_reg_sel)
    );

    // Word layout: p2a rd wr irld pcld psrc asel bsel[2] op[3] rfw wds wrs
    function automatic logic [14:0] mk(input bit p2a, input bit rd, input bit wr,
                                       input bit irl, input bit pcl, input bit ps,
                                       input bit as, input logic [1:0] bs,
                                       input logic [2:0] op, input bit rfw,
                                       input bit wds, input bit wrs);
        return {p2a, rd, wr, irl, pcl, ps, as, bs, op, rfw, wds, wrs};
    endfunction

    function automatic logic [14:0] w_fetch();  return mk(1,1,0,1,1,0,0,2'd1,3'd0,0,0,0); endfunction
    function automatic logic [14:0] w_zero();   return '0; endfunction
    function automatic logic [14:0] w_rtype(input logic [2:0] op);
        return mk(0,0,0,0,0,0,1,2'd0,op,1,0,1);
    endfunction
    function automatic logic [14:0] w_addi();   return mk(0,0,0,0,0,0,1,2'd2,3'd0,1,0,0); endfunction
    function automatic logic [14:0] w_addr();   return mk(0,0,0,0,0,0,1,2'd2,3'd0,0,0,0); endfunction
    function automatic logic [14:0] w_lmem();   return mk(0,1,0,0,0,0,1,2'd2,3'd0,0,0,0); endfunction
    function automatic logic [14:0] w_lwb();    return mk(0,0,0,0,0,0,0,2'd0,3'd0,1,1,0); endfunction
    function automatic logic [14:0] w_smem();   return mk(0,0,1,0,0,0,1,2'd2,3'd0,0,0,0); endfunction
    function automatic logic [14:0] w_bcmp();   return mk(0,0,0,0,0,0,1,2'd0,3'd1,0,0,0); endfunction
    function automatic logic [14:0] w_btake();  return mk(0,0,0,0,1,0,0,2'd2,3'd0,0,0,0); endfunction
    function automatic logic [14:0] w_jump();   return mk(0,0,0,0,1,1,0,2'd0,3'd0,0,0,0); endfunction

    function automatic logic [14:0] actual();
        return {pc_to_addr, mem_rd, mem_wr, ir_ld, pc_ld, pc_src, alu_a_sel,
                alu_b_sel, alu_op, rf_wr, wd_sel, wr_reg_sel};
    endfunction

    task automatic check(input string tag, input logic [14:0] exp);
        logic [14:0] act;
        act = actual();
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %015b expected %015b", tag, $time, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(negedge clk);
    endtask

    // Reset for one edge; on return the controller sits in fetch with rst low.
    task automatic do_reset();
        rst = 1'b1;
        next_cycle();
        check("R1 reset enters fetch", w_fetch());
        rst = 1'b0;
    endtask

    // Runs one instruction starting in its fetch cycle; returns in the next fetch.
    task automatic run_instr(input logic [2:0] op, input logic [3:0] fn, input bit eq);
        ir_op = op; ir_funct = fn; eq_flag = eq;
        check("R2 fetch word", w_fetch());
        next_cycle();
        check("R3 decode word", w_zero());
        next_cycle();
        case (op)
            3'd0: begin
                if (fn <= 4'd4) begin
                    check("R4 register execute", w_rtype(fn[2:0]));
                    next_cycle();
                end
                else check("R11 undefined function back to fetch", w_fetch());
            end
            3'd1: begin
                check("R6 load address", w_addr());   next_cycle();
                check("R6 load read", w_lmem());      next_cycle();
                check("R6 load write-back", w_lwb()); next_cycle();
            end
            3'd2: begin
                check("R7 store address", w_addr()); next_cycle();
                check("R7 store write", w_smem());   next_cycle();
            end
            3'd3: begin
                check("R8 branch compare", w_bcmp()); next_cycle();
                if (eq) begin
                    check("R8 branch taken", w_btake()); next_cycle();
                end
            end
            3'd4: begin
                check("R5 add immediate", w_addi()); next_cycle();
            end
            3'd5: begin
                check("R9 jump", w_jump()); next_cycle();
            end
            3'd6: check("R11 undefined opcode back to fetch", w_fetch());
            default: ;
        endcase
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] op;
        logic [3:0] fn;
        bit eq;
        void'($urandom(32'd20240611));
        next_cycle();
        next_cycle();
        do_reset();

        // Directed: every function code and class
        for (int f = 0; f < 16; f++) run_instr(3'd0, 4'(f), 1'b0);
        run_instr(3'd1, 4'd0, 1'b0);
        run_instr(3'd2, 4'd9, 1'b1);
        run_instr(3'd3, 4'd0, 1'b1);
        run_instr(3'd3, 4'd0, 1'b0);
        run_instr(3'd4, 4'd15, 1'b0);
        run_instr(3'd5, 4'd0, 1'b1);
        run_instr(3'd6, 4'd0, 1'b1);

        // Reset in the middle of a load
        ir_op = 3'd1; ir_funct = 4'd0;
        next_cycle(); next_cycle(); next_cycle();
        check("R6 load read before reset", w_lmem());
        do_reset();

        // Random instruction stream
        for (int i = 0; i < 400; i++) begin
            op = 3'($urandom % 7);
            fn = 4'($urandom % 16);
            if ($urandom % 2) fn = 4'(fn % 5);
            eq = 1'($urandom % 2);
            run_instr(op, fn, eq);
        end

        // Halt: idle regardless of inputs until reset
        ir_op = 3'd7; ir_funct = 4'd0;
        check("R2 fetch before halt", w_fetch());
        next_cycle();
        check("R3 decode before halt", w_zero());
        next_cycle();
        ir_op = 3'd0; eq_flag = 1'b1;
        for (int k = 0; k < 6; k++) begin
            check("R10 halt idle", w_zero());
            ir_op = 3'(k); ir_funct = 4'(k);
            next_cycle();
        end
        do_reset();
        run_instr(3'd0, 4'd1, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule